// File: doc/BRIEF.md
# Single-Window Pixel Read Cache

This block sits between a pixel access port and a byte-addressed backing memory. It keeps a copy of one 4096-byte window of the buffer, aligned to a 4096-byte boundary. A read that falls inside the held window is answered from the local copy. A read outside it first reloads the whole window with a burst from memory and then answers. Writes never update the copy. Each write goes to memory as a single strobed word write, and it discards the window so the next read fetches fresh data.

The block has three access modes. The plain mode serves 8-, 16- and 32-bit little-endian accesses. The packed-colour mode treats every access as a 32-bit pixel: on a read the alpha byte is forced to all ones, and on a write only the three colour bytes change. The stencil mode reaches the stencil byte of a combined depth/stencil pixel, which sits three bytes above the pixel address. A separate flush input discards the window when the buffer is released. A request that is misaligned or uses a reserved code is answered with an error and has no other effect.

Top module: `pixel_window_cache`

## Requirements
- R1: A refill reads the window whose base is the effective request address with bits 11:0 cleared. The read is a single burst command at that base address, and the window is filled from exactly 1024 accepted 32-bit beats in rising address order.
- R2: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_cmd_valid` is 0. The window is invalid, so the first read always refills.
- R3: A read hits when the window is valid and bits 31:12 of its effective address equal the stored window tag. A hit issues no memory command and raises `rsp_valid` 2 cycles after acceptance. A miss reloads the whole window before it responds.
- R4: `req_size` codes are 0 = 8-bit, 1 = 16-bit and 2 = 32-bit. Read data is little-endian: the byte at the lowest address is `rsp_data[7:0]`. Narrow results are zero-extended.
- R5: With `req_mode` = 1 (packed colour), a read returns the 32-bit word at the address with bits 31:24 set to 0xFF, whatever `req_size` is.
- R6: A packed-colour write stores bytes 0 to 2 of `req_wdata` (strobe 4'b0111). The fourth byte in memory keeps its old value.
- R7: With `req_mode` = 2 (stencil), the access is one byte at the request address + 3. A read returns that byte in `rsp_data[7:0]`, and a write stores `req_wdata[7:0]` there, whatever `req_size` is.
- R8: Each valid write of any size invalidates the window. It is issued as one memory write to the word-aligned address, with the data placed on its byte lanes and a matching strobe. `rsp_valid` rises 1 cycle after the memory accepts the command.
- R9: A cycle with `flush` high invalidates the window, so the next read refills.
- R10: A request is rejected if it is a 16-bit access at an odd address, a 32-bit or packed-colour access whose address bits 1:0 are not zero, `req_size` = 3, or `req_mode` = 3. A rejected request gets `rsp_valid` with `rsp_err` = 1 one cycle after acceptance. It issues no memory command and leaves the window unchanged.
- R11: `req_ready` is low from the acceptance of a refilling read or a write until its response. It is also low between acceptance and response for a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access width code |
| req_mode | input | 2 | 0 plain, 1 packed colour, 2 stencil, 3 reserved |
| req_addr | input | ADDR_W | Byte address (pixel address in stencil mode) |
| req_wdata | input | 32 | Write data, right-aligned |
| flush | input | 1 | Discard the held window |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Request was rejected |
| rsp_data | output | 32 | Read result (0 for writes and errors) |
| mem_cmd_valid | output | 1 | Memory command present |
| mem_cmd_ready | input | 1 | Memory accepts the command |
| mem_cmd_write | output | 1 | 1 = single word write, 0 = window burst read |
| mem_cmd_addr | output | ADDR_W | Word-aligned write address or window base |
| mem_cmd_wdata | output | 32 | Write data on its byte lanes |
| mem_cmd_wstrb | output | 4 | Byte enables for the write |
| mem_rvalid | input | 1 | Burst beat present |
| mem_rdata | input | 32 | Burst beat data |

## Verification
A hit is due exactly two cycles after acceptance, an error one cycle after, and a write one cycle after its memory command is taken. The bench measures each of these latencies by counting falling edges from the acceptance edge. Refills depend on how the memory paces the burst, which includes inserted gaps, so they are checked by the number and base address of the burst commands the memory model sees. `req_ready` is also sampled in the middle of a refill. Every sample is taken on a falling edge, after the registers have settled from the preceding rising edge.

// File: rtl/pwc_pkg.sv
// Shared types and decode helpers for the pixel window cache.
// Assumes a 32-bit data path and 4-byte memory beats.
package pwc_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        MD_PLAIN   = 2'd0,
        MD_XRGB    = 2'd1,
        MD_STENCIL = 2'd2,
        MD_RSVD    = 2'd3
    } acc_mode_e;

    localparam int STENCIL_OFS = 3;

    // Width actually used once the mode has been applied.
    function automatic acc_size_e eff_size(acc_mode_e m, acc_size_e s);
        if (m == MD_XRGB)    return SZ_WORD;
        if (m == MD_STENCIL) return SZ_BYTE;
        return s;
    endfunction

    // Returns 1 when the request must be rejected.
    function automatic logic bad_access(acc_mode_e m, acc_size_e s, logic [1:0] lo);
        acc_size_e es;
        es = eff_size(m, s);
        if (m == MD_RSVD) return 1'b1;
        case (es)
            SZ_BYTE: return 1'b0;
            SZ_HALF: return lo[0];
            SZ_WORD: return lo != 2'b00;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/pwc_window_store.sv
// Window storage: one word per 4 bytes of the window.
// Written only by the refill burst. Read combinationally at a word index.
// Has no reset: contents matter only while the controller marks them valid.
module pwc_window_store #(
    parameter int WORDS = 1024,
    parameter int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data
);
    logic [31:0] mem_q [WORDS];

    // Capture refill beats.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_data;
    end

    // Serve the word that holds the latched request.
    always_comb rd_data = mem_q[rd_idx];

endmodule

// File: rtl/pwc_lane_unit.sv
// Byte-lane steering. On the read side it extracts a little-endian field
// from a stored word and applies alpha forcing. On the write side it places
// data on its lanes and builds the strobe.
// Assumes the size has already been resolved by the mode (pwc_pkg::eff_size)
// and the access is aligned.
module pwc_lane_unit
    import pwc_pkg::*;
(
    input  logic [31:0] word_in,
    input  logic [1:0]  lo,
    input  acc_size_e   size,
    input  acc_mode_e   mode,
    input  logic [31:0] wdata,
    output logic [31:0] rd_val,
    output logic [31:0] wr_word,
    output logic [3:0]  wr_strb
);
    logic [31:0] shifted;

    // Read field extraction, zero-extended, with alpha forced in packed mode.
    always_comb begin
        shifted = word_in >> {lo, 3'b000};
        case (size)
            SZ_BYTE: rd_val = {24'h0, shifted[7:0]};
            SZ_HALF: rd_val = {16'h0, shifted[15:0]};
            default: rd_val = word_in;
        endcase
        if (mode == MD_XRGB) rd_val[31:24] = 8'hFF;
    end

    // Write lane placement and byte enables.
    always_comb begin
        wr_word = wdata << {lo, 3'b000};
        case (size)
            SZ_BYTE: wr_strb = 4'b0001 << lo;
            SZ_HALF: wr_strb = 4'b0011 << lo;
            default: wr_strb = (mode == MD_XRGB) ? 4'b0111 : 4'b1111;
        endcase
    end

endmodule

// File: rtl/pwc_ctrl.sv
// Sequencer and window tag for the pixel window cache.
// Accepts one request at a time. It resolves hit or miss against the single
// window tag, runs the refill burst or the write-through, and registers the
// response. Assumes the memory returns refill beats in address order, and
// only after the burst command has been accepted.
module pwc_ctrl
    import pwc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WIN_BYTES = 4096,
    localparam int OFF_W    = $clog2(WIN_BYTES),
    localparam int WORDS    = WIN_BYTES / 4,
    localparam int IDX_W    = OFF_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  acc_size_e         req_size,
    input  acc_mode_e         req_mode,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              flush,
    output logic [ADDR_W-1:0] q_addr,
    output acc_size_e         q_size,
    output acc_mode_e         q_mode,
    output logic [31:0]       q_wdata,
    output logic              q_write,
    output logic              st_we,
    output logic [IDX_W-1:0]  st_idx,
    output logic [31:0]       st_data,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [31:0]       rd_val,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_data,
    output logic              mem_cmd_valid,
    input  logic              mem_cmd_ready,
    output logic              mem_cmd_write,
    output logic [ADDR_W-1:0] mem_cmd_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata
);
    typedef enum logic [2:0] {
        S_IDLE, S_FILL_REQ, S_FILL_DATA, S_READ_OUT, S_WR_REQ
    } state_e;

    state_e                   state;
    logic [ADDR_W-OFF_W-1:0]  tag_q;
    logic                     win_valid;
    logic                     flush_seen;
    logic [IDX_W-1:0]         beat_cnt;
    logic [ADDR_W-1:0]        in_eff;
    logic                     in_bad, in_hit, accept, last_beat;

    // Request decode: effective address, rejection and hit test.
    always_comb begin
        in_eff    = req_addr + ((req_mode == MD_STENCIL) ? ADDR_W'(STENCIL_OFS) : '0);
        in_bad    = bad_access(req_mode, req_size, in_eff[1:0]);
        in_hit    = win_valid && !flush && (in_eff[ADDR_W-1:OFF_W] == tag_q);
        req_ready = (state == S_IDLE);
        accept    = req_valid && req_ready;
    end

    // Memory command, storage write port and storage read index.
    always_comb begin
        mem_cmd_valid = (state == S_FILL_REQ) || (state == S_WR_REQ);
        mem_cmd_write = (state == S_WR_REQ);
        mem_cmd_addr  = (state == S_FILL_REQ) ? {q_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}
                                              : {q_addr[ADDR_W-1:2], 2'b00};
        st_we         = (state == S_FILL_DATA) && mem_rvalid;
        st_idx        = beat_cnt;
        st_data       = mem_rdata;
        rd_idx        = q_addr[OFF_W-1:2];
        last_beat     = st_we && (beat_cnt == IDX_W'(WORDS - 1));
    end

    // Main sequencer: latch the request, run fill or write, emit the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            tag_q     <= '0;
            beat_cnt  <= '0;
            q_addr    <= '0;
            q_size    <= SZ_BYTE;
            q_mode    <= MD_PLAIN;
            q_wdata   <= '0;
            q_write   <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                S_IDLE: if (accept) begin
                    q_addr  <= in_eff;
                    q_size  <= eff_size(req_mode, req_size);
                    q_mode  <= req_mode;
                    q_wdata <= req_wdata;
                    q_write <= req_write;
                    if (in_bad) begin
                        rsp_valid <= 1'b1;
                        rsp_err   <= 1'b1;
                        rsp_data  <= '0;
                    end else if (req_write) begin
                        state <= S_WR_REQ;
                    end else if (in_hit) begin
                        state <= S_READ_OUT;
                    end else begin
                        state <= S_FILL_REQ;
                    end
                end
                S_FILL_REQ: if (mem_cmd_ready) begin
                    state    <= S_FILL_DATA;
                    beat_cnt <= '0;
                end
                S_FILL_DATA: if (st_we) begin
                    beat_cnt <= beat_cnt + 1'b1;
                    if (last_beat) begin
                        tag_q <= q_addr[ADDR_W-1:OFF_W];
                        state <= S_READ_OUT;
                    end
                end
                S_READ_OUT: begin
                    rsp_valid <= 1'b1;
                    rsp_err   <= 1'b0;
                    rsp_data  <= rd_val;
                    state     <= S_IDLE;
                end
                S_WR_REQ: if (mem_cmd_ready) begin
                    rsp_valid <= 1'b1;
                    rsp_err   <= 1'b0;
                    rsp_data  <= '0;
                    state     <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Window validity: cleared by writes and flush, set when a clean fill completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_valid <= 1'b0;
        end else if (flush || (accept && req_write && !in_bad)) begin
            win_valid <= 1'b0;
        end else if (last_beat && !flush_seen) begin
            win_valid <= 1'b1;
        end
    end

    // Remember a flush that arrives while a fill is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)                        flush_seen <= 1'b0;
        else if (accept)                   flush_seen <= 1'b0;
        else if (flush && state != S_IDLE) flush_seen <= 1'b1;
    end

    p_write_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept && req_write && !in_bad |=> !win_valid);

    p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !win_valid);

    p_bad_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept && in_bad |=> rsp_valid && rsp_err && !mem_cmd_valid);

    p_hit_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !req_write && !in_bad && in_hit |=> !mem_cmd_valid && !req_ready);

    p_alpha_forced_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_err && !q_write && q_mode == MD_XRGB |-> rsp_data[31:24] == 8'hFF);

endmodule

// File: rtl/pixel_window_cache.sv
// Single-window pixel read cache: top level.
// Connects the sequencer, the window storage and the lane steering.
// Assumes one outstanding request, and a memory that answers a burst
// command with exactly one window of beats.
module pixel_window_cache
    import pwc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WIN_BYTES = 4096,
    localparam int WORDS    = WIN_BYTES / 4,
    localparam int IDX_W    = $clog2(WIN_BYTES) - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [1:0]        req_mode,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              flush,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_data,
    output logic              mem_cmd_valid,
    input  logic              mem_cmd_ready,
    output logic              mem_cmd_write,
    output logic [ADDR_W-1:0] mem_cmd_addr,
    output logic [31:0]       mem_cmd_wdata,
    output logic [3:0]        mem_cmd_wstrb,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata
);
    logic [ADDR_W-1:0] q_addr;
    acc_size_e         q_size;
    acc_mode_e         q_mode;
    logic [31:0]       q_wdata;
    logic              q_write;
    logic              st_we;
    logic [IDX_W-1:0]  st_idx, rd_idx;
    logic [31:0]       st_data, rd_word, rd_val;

    pwc_ctrl #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(acc_size_e'(req_size)), .req_mode(acc_mode_e'(req_mode)),
        .req_addr(req_addr), .req_wdata(req_wdata), .flush(flush),
        .q_addr(q_addr), .q_size(q_size), .q_mode(q_mode),
        .q_wdata(q_wdata), .q_write(q_write),
        .st_we(st_we), .st_idx(st_idx), .st_data(st_data),
        .rd_idx(rd_idx), .rd_val(rd_val),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
        .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
        .mem_cmd_write(mem_cmd_write), .mem_cmd_addr(mem_cmd_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    pwc_window_store #(.WORDS(WORDS), .IDX_W(IDX_W)) u_store (
        .clk(clk), .wr_en(st_we), .wr_idx(st_idx), .wr_data(st_data),
        .rd_idx(rd_idx), .rd_data(rd_word)
    );

    pwc_lane_unit u_lane (
        .word_in(rd_word), .lo(q_addr[1:0]), .size(q_size), .mode(q_mode),
        .wdata(q_wdata), .rd_val(rd_val),
        .wr_word(mem_cmd_wdata), .wr_strb(mem_cmd_wstrb)
    );

    p_xrgb_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_valid && mem_cmd_write && q_mode == MD_XRGB |-> mem_cmd_wstrb == 4'b0111);

    p_stencil_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_valid && mem_cmd_write && q_mode == MD_STENCIL |-> $countones(mem_cmd_wstrb) == 1);

endmodule

// File: tb/pixel_window_cache_test.sv
// Self-checking bench for pixel_window_cache: sweeps every lane and size
// over a window, and runs misses, aliasing, writes, flush and rejects
// against a byte-array memory model.
module pixel_window_cache_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, flush = 1'b0;
    logic [1:0]  req_size = 2'd0, req_mode = 2'd0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_err;
    logic [31:0] rsp_data;
    logic        mem_cmd_valid, mem_cmd_write;
    logic        mem_cmd_ready = 1'b1;
    logic [31:0] mem_cmd_addr, mem_cmd_wdata;
    logic [3:0]  mem_cmd_wstrb;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #10 clk = ~clk;  // 50 MHz

    pixel_window_cache uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_size(req_size), .req_mode(req_mode),
        .req_addr(req_addr), .req_wdata(req_wdata), .flush(flush),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
        .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
        .mem_cmd_write(mem_cmd_write), .mem_cmd_addr(mem_cmd_addr),
        .mem_cmd_wdata(mem_cmd_wdata), .mem_cmd_wstrb(mem_cmd_wstrb),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int nvec = 0, nfail = 0;
    logic [7:0] bmem [16384];
    int fill_count = 0, wr_count = 0;
    int last_base = -1;
    int strm_left = 0, strm_addr = 0, beat_n = 0;
    bit strm_arm = 0;
    int arm_base = 0;
    bit done = 0;

    function automatic logic [7:0] init_byte(int a);
        return 8'((a * 7) + ((a >> 8) * 13) + 5);
    endfunction

    function automatic logic [31:0] bword(int a);
        int b;
        b = (a & 16383) & ~3;
        return {bmem[b+3], bmem[b+2], bmem[b+1], bmem[b]};
    endfunction

    // Expected read value computed from the memory image.
    function automatic logic [31:0] exp_read(logic [1:0] md, logic [1:0] sz, int a);
        int ea;
        logic [31:0] w;
        ea = (md == 2'd2) ? a + 3 : a;
        w = bword(ea);
        w = w >> (8 * (ea & 3));
        if (md == 2'd1) return bword(ea) | 32'hFF00_0000;
        if (md == 2'd2 || sz == 2'd0) return {24'h0, w[7:0]};
        if (sz == 2'd1) return {16'h0, w[15:0]};
        return bword(ea);
    endfunction

    // Memory model: burst reads (with gaps) and strobed word writes, driven on the falling edge.
    always @(negedge clk) begin
        if (strm_arm) begin
            strm_left = 1024;
            strm_addr = arm_base;
            strm_arm = 0;
            beat_n = 0;
        end
        mem_rvalid = 1'b0;
        if (strm_left > 0) begin
            beat_n++;
            if (beat_n % 5 != 4) begin
                mem_rvalid = 1'b1;
                mem_rdata = bword(strm_addr);
                strm_addr += 4;
                strm_left--;
            end
        end
        if (mem_cmd_valid && mem_cmd_ready) begin
            if (mem_cmd_write) begin
                wr_count++;
                for (int k = 0; k < 4; k++)
                    if (mem_cmd_wstrb[k])
                        bmem[(int'(mem_cmd_addr) & 16380) + k] = mem_cmd_wdata[8*k +: 8];
            end else begin
                fill_count++;
                last_base = int'(mem_cmd_addr);
                arm_base = int'(mem_cmd_addr) & 16383;
                strm_arm = 1;
            end
        end
    end

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // One request; returns the data, error flag and the cycles from acceptance to response.
    task automatic xfer(input logic w, input logic [1:0] sz, input logic [1:0] md,
                        input int a, input logic [31:0] wd,
                        output logic [31:0] d, output logic e, output int lat);
        req_valid = 1'b1; req_write = w; req_size = sz; req_mode = md;
        req_addr = 32'(a); req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid) begin @(negedge clk); lat++; end
        d = rsp_data; e = rsp_err;
    endtask

    // Read and check data, error and hit or miss.
    task automatic rd_chk(input string rq, input logic [1:0] sz, input logic [1:0] md,
                          input int a, input bit expect_miss);
        logic [31:0] d; logic e; int lat; int f0;
        logic [31:0] x;
        x = exp_read(md, sz, a);
        f0 = fill_count;
        xfer(1'b0, sz, md, a, 32'h0, d, e, lat);
        check(rq, d, x);
        check(rq, 32'(e), 32'd0);
        check(rq, 32'(fill_count - f0), expect_miss ? 32'd1 : 32'd0);
        if (!expect_miss) check({rq, " hit latency"}, 32'(lat), 32'd2);
    endtask

    task automatic err_chk(input string rq, input logic w, input logic [1:0] sz,
                           input logic [1:0] md, input int a);
        logic [31:0] d; logic e; int lat; int f0, w0;
        f0 = fill_count; w0 = wr_count;
        xfer(w, sz, md, a, 32'hA5A5_A5A5, d, e, lat);
        check(rq, 32'(e), 32'd1);
        check(rq, 32'(lat), 32'd1);
        check(rq, 32'(fill_count - f0 + wr_count - w0), 32'd0);
    endtask

    task automatic wr_do(input string rq, input logic [1:0] sz, input logic [1:0] md,
                         input int a, input logic [31:0] wd);
        logic [31:0] d; logic e; int lat; int w0;
        w0 = wr_count;
        xfer(1'b1, sz, md, a, wd, d, e, lat);
        check(rq, 32'(e), 32'd0);
        check(rq, 32'(lat), 32'd2);
        check(rq, 32'(wr_count - w0), 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d; logic e; int lat; int f0;
        for (int i = 0; i < 16384; i++) bmem[i] = init_byte(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        check("R2 ready", 32'(req_ready), 32'd1);
        check("R2 rsp", 32'(rsp_valid), 32'd0);
        check("R2 cmd", 32'(mem_cmd_valid), 32'd0);

        // R2/R1: first read refills window 0
        rd_chk("R2 first read", 2'd0, 2'd0, 32'h105, 1'b1);
        check("R1 base", 32'(last_base), 32'h0);

        // R3/R4: sweep byte, half and word lanes inside the window, all hits
        for (int o = 0; o < 128; o++)      rd_chk("R4 byte", 2'd0, 2'd0, 32'h100 + o, 1'b0);
        for (int o = 0; o < 128; o += 2)   rd_chk("R4 half", 2'd1, 2'd0, 32'h100 + o, 1'b0);
        for (int o = 0; o < 128; o += 4)   rd_chk("R4 word", 2'd2, 2'd0, 32'hF80 + o, 1'b0);

        // R1/R11: miss to window 1, ready low during the refill
        f0 = fill_count;
        req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2; req_mode = 2'd0;
        req_addr = 32'h1A38;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (6) @(negedge clk);
        check("R11 ready in fill", 32'(req_ready), 32'd0);
        check("R11 no rsp in fill", 32'(rsp_valid), 32'd0);
        while (!rsp_valid) @(negedge clk);
        check("R1 window1 data", rsp_data, exp_read(2'd0, 2'd2, 32'h1A38));
        check("R1 base window1", 32'(last_base), 32'h1000);
        check("R3 one fill", 32'(fill_count - f0), 32'd1);
        rd_chk("R3 window1 hit", 2'd2, 2'd0, 32'h1FFC, 1'b0);
        rd_chk("R3 back to window0", 2'd1, 2'd0, 32'h0FFE, 1'b1);
        // R3: tag compares high bits, 0x4100 aliases 0x100 in the model but is another window
        rd_chk("R3 alias refill", 2'd2, 2'd0, 32'h4100, 1'b1);
        check("R1 alias base", 32'(last_base), 32'h4000);
        rd_chk("R3 alias hit", 2'd0, 2'd0, 32'h4FFF, 1'b0);

        // R5: packed-colour read, alpha forced, size ignored
        rd_chk("R5 xrgb", 2'd0, 2'd1, 32'h4200, 1'b0);
        rd_chk("R5 xrgb2", 2'd2, 2'd1, 32'h4ABC, 1'b0);
        // R7: stencil byte at pixel + 3
        rd_chk("R7 stencil read", 2'd2, 2'd2, 32'h4300, 1'b0);
        rd_chk("R7 stencil read2", 2'd0, 2'd2, 32'h4FF4, 1'b0);

        // R8: writes go through with lanes and strobes, then the window is gone
        wr_do("R8 word write", 2'd2, 2'd0, 32'h0400, 32'hDEAD_BEEF);
        check("R8 word mem", bword(32'h400), 32'hDEAD_BEEF);
        rd_chk("R8 refill after write", 2'd2, 2'd0, 32'h0400, 1'b1);
        wr_do("R8 byte write", 2'd0, 2'd0, 32'h0405, 32'h0000_005A);
        check("R8 byte lane", bword(32'h404),
              {init_byte(32'h407), init_byte(32'h406), 8'h5A, init_byte(32'h404)});
        rd_chk("R8 refill byte", 2'd0, 2'd0, 32'h0405, 1'b1);
        wr_do("R8 half write", 2'd1, 2'd0, 32'h040A, 32'h0000_1234);
        check("R8 half lane", bword(32'h408),
              {16'h1234, init_byte(32'h409), init_byte(32'h408)});
        rd_chk("R8 refill half", 2'd1, 2'd0, 32'h040A, 1'b1);

        // R6: packed-colour write keeps the top byte
        wr_do("R6 xrgb write", 2'd2, 2'd1, 32'h0410, 32'h1122_3344);
        check("R6 top byte kept", bword(32'h410), {init_byte(32'h413), 24'h223344});
        rd_chk("R6 xrgb readback", 2'd2, 2'd1, 32'h0410, 1'b1);
        check("R6 alpha", exp_read(2'd1, 2'd2, 32'h0410), 32'hFF22_3344);

        // R7: stencil write touches only pixel + 3
        wr_do("R7 stencil write", 2'd2, 2'd2, 32'h0420, 32'hFFFF_FF77);
        check("R7 stencil mem", bword(32'h420),
              {8'h77, init_byte(32'h422), init_byte(32'h421), init_byte(32'h420)});
        rd_chk("R7 stencil readback", 2'd0, 2'd2, 32'h0420, 1'b1);

        // R9: flush forces a refill, without it the read hits
        rd_chk("R9 baseline hit", 2'd2, 2'd0, 32'h0500, 1'b0);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        rd_chk("R9 flush refill", 2'd2, 2'd0, 32'h0500, 1'b1);

        // R10: rejects, no memory traffic, window kept
        err_chk("R10 half odd", 1'b0, 2'd1, 2'd0, 32'h0501);
        err_chk("R10 word off", 1'b0, 2'd2, 2'd0, 32'h0502);
        err_chk("R10 size3", 1'b0, 2'd3, 2'd0, 32'h0500);
        err_chk("R10 mode3", 1'b0, 2'd0, 2'd3, 32'h0500);
        err_chk("R10 xrgb off", 1'b0, 2'd2, 2'd1, 32'h0503);
        err_chk("R10 write off", 1'b1, 2'd2, 2'd0, 32'h0506);
        rd_chk("R10 window kept", 2'd2, 2'd0, 32'h0504, 1'b0);

        // R11: ready returns high after the response
        check("R11 ready idle", 32'(req_ready), 32'd1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule